// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address after a TLB miss. It walks a radix page table with three levels in memory. The walk starts from a table root page number. At each level it reads one 8-byte entry, and the entry address is formed from the current page number and a 10-bit slice of the virtual address. Each entry gives a 32-bit page number. The page number from the third level is joined with the 13-bit page offset to form a 45-bit physical address.

Any entry whose valid bit is clear ends the walk at once. The block then reports a fault that names the level where the walk stopped. Only one walk runs at a time, and the block takes a new request only while it is idle. TLB storage and fault recovery belong to the surrounding logic.

Top module: `ptw_top`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the acceptance until the response, and a request offered during a walk is ignored.
- R3: The first read address is the root page number followed by virtual address bits 42:33 and then three zero bits: {root, va[42:33], 3'b000}.
- R4: The second and third reads use the page number from bits 63:32 of the previous entry. Their indices are va[32:23] and va[22:13], and the same address layout as R3 applies.
- R5: When all three entries are valid, the response has `rsp_fault` = 0, `rsp_level` = 0 and `rsp_pa` = {third entry bits 63:32, va[12:0]}.
- R6: An entry with bit 0 clear ends the walk. The response has `rsp_fault` = 1, `rsp_level` set to that level (1, 2 or 3) and `rsp_pa` = 0, and no further read is issued.
- R7: `mem_req_valid` is held with a stable `mem_req_addr` until `mem_req_ready` is seen. It is low while the block waits for read data.
- R8: `rsp_valid` is a one-cycle pulse. It is raised in the cycle after the data beat that ends the walk, and there is exactly one pulse per accepted request.
- R9: Virtual address bits 63:43 have no effect, and the request inputs are sampled only at acceptance.
- R10: Entry bits 31:1 have no effect on addresses or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and can accept a request |
| req_va | input | 64 | Virtual address to translate |
| root_ppn | input | 32 | Page number of the level-1 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 45 | Byte address of the entry |
| mem_resp_valid | input | 1 | Read data beat |
| mem_resp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Walk result pulse |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_level | output | 2 | Level of the faulting entry (1 to 3); 0 on success |
| rsp_pa | output | 45 | Physical address; 0 on fault |

## Verification
Fixed directed walks cover the index extremes (all-zero and all-one fields) and the largest page number. These cases show whether the index slices are in the right place and at the right level. Walks are set up to fail at each of the three levels. They show whether a fault ends the walk at the correct depth and whether the reported level is right. Random walks use random upper address bits, random junk in the unused entry bits and random memory handshake delays. They separate genuine dependence on the page number fields from accidental dependence on ignored bits, and they check correct hold behaviour under back-pressure. Some walks offer a conflicting request during the walk, which shows whether a busy walker takes a request it should ignore.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_state_t;
endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int VA_W   = 64,
  parameter int OFF_W  = 13,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] fields [LEVELS];

  // level 0 is the topmost index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign fields[g] = va[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx = fields[i];
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W  = 32,
  parameter int IDX_W  = 10,
  parameter int PTE_LG = 3,
  localparam int AW    = PPN_W + IDX_W + PTE_LG
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  // page base plus index times entry size; the index never carries into the page number
  assign addr = {ppn, idx, {PTE_LG{1'b0}}};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int OFF_W   = 13,
  parameter int PPN_W   = 32,
  parameter int ENT_W   = 64,
  parameter int PPN_LSB = 32,
  parameter int LEVELS  = 3,
  parameter int LVL_W   = 2,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PPN_W-1:0] root_ppn,
  output logic [VA_W-1:0]  va_q,
  output logic [PPN_W-1:0] ppn_q,
  output logic [LVL_W-1:0] level_q,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_resp_valid,
  input  logic [ENT_W-1:0] mem_resp_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [LVL_W-1:0] rsp_level,
  output logic [PA_W-1:0]  rsp_pa
);
  walk_state_t st;
  logic [PPN_W-1:0] ent_ppn;
  logic             ent_ok;

  assign ent_ppn       = mem_resp_data[PPN_LSB +: PPN_W];
  assign ent_ok        = mem_resp_data[0];
  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      ppn_q     <= '0;
      level_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_level <= '0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            ppn_q   <= root_ppn;
            level_q <= '0;
            st      <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_resp_valid) begin
            if (!ent_ok) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_level <= level_q + LVL_W'(1);
              rsp_pa    <= '0;
              st        <= ST_IDLE;
            end else if (level_q == LVL_W'(LEVELS-1)) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_level <= '0;
              rsp_pa    <= {ent_ppn, va_q[OFF_W-1:0]};
              st        <= ST_IDLE;
            end else begin
              ppn_q   <= ent_ppn;
              level_q <= level_q + LVL_W'(1);
              st      <= ST_REQ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int VA_W    = 64,
  parameter int OFF_W   = 13,
  parameter int PTE_LG  = 3,
  parameter int LEVELS  = 3,
  parameter int PPN_W   = 32,
  parameter int ENT_W   = 64,
  parameter int PPN_LSB = 32,
  localparam int IDX_W  = OFF_W - PTE_LG,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_resp_valid,
  input  logic [ENT_W-1:0] mem_resp_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [LVL_W-1:0] rsp_level,
  output logic [PA_W-1:0]  rsp_pa
);
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] ppn_q;
  logic [LVL_W-1:0] level_q;
  logic [IDX_W-1:0] idx;

  ptw_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ENT_W(ENT_W),
    .PPN_LSB(PPN_LSB), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .root_ppn(root_ppn),
    .va_q(va_q), .ppn_q(ppn_q), .level_q(level_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_pa(rsp_pa)
  );

  ptw_idx_sel #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_idx (
    .va(va_q), .level(level_q), .idx(idx)
  );

  ptw_addr_gen #(
    .PPN_W(PPN_W), .IDX_W(IDX_W), .PTE_LG(PTE_LG)
  ) u_addr (
    .ppn(ppn_q), .idx(idx), .addr(mem_req_addr)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int PA_W  = 45,
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_resp_valid,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [LVL_W-1:0] rsp_level,
  input logic [PA_W-1:0]  rsp_pa
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !mem_req_valid));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_no_accept_in_walk_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_no_req_after_handshake_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_needs_beat_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(mem_resp_valid));

  p_fault_fields_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_level != '0 && rsp_pa == '0));

  p_ok_level_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_level == '0));
endmodule

bind ptw_top ptw_chk #(.PA_W(PA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_level(rsp_level), .rsp_pa(rsp_pa)
);

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [31:0] root_ppn = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [44:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [63:0] mem_resp_data = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic [44:0] rsp_pa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptw_top u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .root_ppn(root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level), .rsp_pa(rsp_pa)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_idx(input logic [63:0] va, input int lv);
    case (lv)
      0: return va[42:33];
      1: return va[32:23];
      default: return va[22:13];
    endcase
  endfunction

  function automatic logic [44:0] exp_addr(input logic [31:0] ppn, input logic [63:0] va, input int lv);
    return {ppn, exp_idx(va, lv), 3'b000};
  endfunction

  function automatic logic [63:0] mk_ent(input logic [31:0] ppn, input bit ok);
    logic [30:0] junk;
    junk = 31'($urandom());  // R10: noise in bits 31:1
    return {ppn, junk, ok};
  endfunction

  task automatic walk(input logic [63:0] va, input logic [31:0] root,
                      input logic [63:0] e0, input logic [63:0] e1, input logic [63:0] e2,
                      input bit poke);
    logic [31:0] ppn;
    logic [63:0] ent;
    int fault_lv;
    int n;
    ppn = root;
    fault_lv = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_va = va; root_ppn = root;
    @(negedge clk);
    req_valid = 1'b0;
    req_va = {$urandom(), $urandom()};   // R9: inputs after acceptance ignored
    root_ppn = $urandom();
    chk(req_ready == 1'b0, "R2 busy", 64'(req_ready), 64'd0);
    for (int lv = 0; lv < 3; lv++) begin
      ent = (lv == 0) ? e0 : (lv == 1) ? e1 : e2;
      n = 0;
      while (!mem_req_valid && n < 20) begin @(negedge clk); n++; end
      chk(mem_req_valid == 1'b1, "R4 read issued", 64'(mem_req_valid), 64'd1);
      chk(mem_req_addr == exp_addr(ppn, va, lv), (lv == 0) ? "R3 root address" : "R4 entry address",
          64'(mem_req_addr), 64'(exp_addr(ppn, va, lv)));
      n = $urandom_range(0, 3);
      for (int d = 0; d < n; d++) begin
        if (poke) begin
          req_valid = 1'b1; req_va = ~va; root_ppn = ~root;
        end
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == exp_addr(ppn, va, lv), "R7 hold",
            64'(mem_req_addr), 64'(exp_addr(ppn, va, lv)));
      end
      req_valid = 1'b0;
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      n = $urandom_range(0, 3);
      for (int d = 0; d < n; d++) @(negedge clk);
      chk(mem_req_valid == 1'b0, "R7 idle while waiting", 64'(mem_req_valid), 64'd0);
      mem_resp_valid = 1'b1; mem_resp_data = ent;
      @(negedge clk);
      mem_resp_valid = 1'b0; mem_resp_data = {$urandom(), $urandom()};
      if (!ent[0]) begin fault_lv = lv + 1; break; end
      ppn = ent[63:32];
    end
    chk(rsp_valid == 1'b1, "R8 pulse timing", 64'(rsp_valid), 64'd1);
    if (fault_lv != 0) begin
      chk(rsp_fault == 1'b1 && rsp_level == 2'(fault_lv) && rsp_pa == '0, "R6 fault result",
          {17'(rsp_fault), 2'(rsp_level), rsp_pa}, {17'd1, 2'(fault_lv), 45'd0});
    end else begin
      chk(rsp_fault == 1'b0 && rsp_level == 2'd0 && rsp_pa == {e2[63:32], va[12:0]}, "R5 final address",
          {17'(rsp_fault), 2'(rsp_level), rsp_pa}, {19'd0, e2[63:32], va[12:0]});
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 single pulse", 64'(rsp_valid), 64'd0);
    chk(mem_req_valid == 1'b0 && req_ready == 1'b1, "R6 no further read, R2 idle",
        {62'd0, mem_req_valid, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] va;
    logic [31:0] rt;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 reset state",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);

    // directed: zero indices, all-ones indices, max page numbers
    walk(64'h0, 32'h0, mk_ent(32'h1, 1), mk_ent(32'h2, 1), mk_ent(32'h3, 1), 0);
    walk(64'h0000_07FF_FFFF_E000, 32'h1234_5678, mk_ent(32'hFFFF_FFFF, 1),
         mk_ent(32'hAAAA_5555, 1), mk_ent(32'hFFFF_FFFF, 1), 0);
    // R9: same translation with different upper bits
    walk(64'hFFFF_F800_1234_5ABC, 32'h0000_00FF, mk_ent(32'h10, 1), mk_ent(32'h20, 1), mk_ent(32'h30, 1), 0);
    walk(64'h0000_0000_1234_5ABC, 32'h0000_00FF, mk_ent(32'h10, 1), mk_ent(32'h20, 1), mk_ent(32'h30, 1), 0);
    // R6: fault at each level
    walk(64'h0000_0123_4567_89AB, 32'h0ABC_DEF0, mk_ent(32'h55, 0), mk_ent(32'h66, 1), mk_ent(32'h77, 1), 0);
    walk(64'h0000_0123_4567_89AB, 32'h0ABC_DEF0, mk_ent(32'h55, 1), mk_ent(32'h66, 0), mk_ent(32'h77, 1), 0);
    walk(64'h0000_0123_4567_89AB, 32'h0ABC_DEF0, mk_ent(32'h55, 1), mk_ent(32'h66, 1), mk_ent(32'h77, 0), 1);
    // R2: conflicting requests offered during a walk
    walk(64'h0000_0456_0000_1FFF, 32'h0000_0001, mk_ent(32'h9, 1), mk_ent(32'h8, 1), mk_ent(32'h7, 1), 1);

    // random walks
    for (int t = 0; t < 300; t++) begin
      va = {$urandom(), $urandom()};
      rt = $urandom();
      walk(va, rt,
           mk_ent($urandom(), $urandom_range(0, 9) != 0),
           mk_ent($urandom(), $urandom_range(0, 9) != 0),
           mk_ent($urandom(), $urandom_range(0, 9) != 0),
           $urandom_range(0, 3) == 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule